// File: doc/BRIEF.md
# Cascadable Fall-Through Queue

This block is a synchronous queue built from a chain of identical stages. Each stage presents its oldest word on its output as soon as the word is available, without any read request. Every stage uses two active-low ready flags. The output-ready flag of one stage is wired straight to the write enable of the next stage. The input-ready flag of a stage is wired straight to the read enable of the stage before it. Words therefore move forward and free slots move backward with no logic between the stages.

The top level places a parameter-set number of stages on one common clock. The first stage's write port and the last stage's read port form the block's interface. Each stage holds a fixed flag latency: three cycles from an accepted write to its output flag, and two cycles from an accepted read to its input flag. The chain latencies therefore grow in fixed steps with the stage count. The reset input asserts asynchronously and is released on the second clock edge after it goes high.

Top module: `fwft_chain`

## Requirements
- R1: While reset is held, and after it is released with no traffic, out_ready_n is 1, in_ready_n is 0 and rd_data is all zeros.
- R2: A word written into an empty stage shows up on rd_data with out_ready_n at 0, and no read is needed for that. The word and the flag stay unchanged until a read is accepted. Reading the last word sets out_ready_n back to 1.
- R3: In a single stage, a write accepted at clock edge k leaves out_ready_n at 1 after edge k+2 and sets it to 0 after edge k+3.
- R4: In an empty chain of N stages, a write accepted at edge k leaves out_ready_n at 1 after edge k+4(N-1)+2. It sets out_ready_n to 0 after edge k+4(N-1)+3, with that word on rd_data.
- R5: With no reads, the chain accepts exactly N*STAGE_DEPTH words and then holds in_ready_n at 1.
- R6: In a full chain of N stages, a read accepted at edge k leaves in_ready_n at 1 after edge k+3(N-1)+1 and sets it to 0 after edge k+3(N-1)+2.
- R7: Words leave the chain in the order they were written. With STAGE_DEPTH of at least 8, a burst written on consecutive cycles while rd_en_n is held at 0 comes out on consecutive cycles with no gap after the first word.
- R8: A write is accepted only at an edge where wr_en_n is 0 and in_ready_n is 0. A write attempted while in_ready_n is 1 is dropped and leaves the stored words unchanged.
- R9: A read is accepted only at an edge where rd_en_n is 0 and out_ready_n is 0. A read attempted on an empty chain has no effect on later words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for every stage |
| arst_n | input | 1 | Active-low reset, asserted asynchronously, released on the second clock edge |
| wr_data | input | WIDTH (18) | Word written into the first stage |
| wr_en_n | input | 1 | Active-low write request |
| in_ready_n | output | 1 | Active-low: the first stage has a free slot |
| rd_data | output | WIDTH (18) | Oldest word, held at the last stage output |
| rd_en_n | input | 1 | Active-low read request |
| out_ready_n | output | 1 | Active-low: rd_data holds a valid word |

## Verification
The in-module properties check, on every cycle and in every stage, the local rules. Occupancy never goes above the depth. Committed words never outnumber held words. The head word stays stable while no read is accepted. A word that has been committed falls through without a read. Requests made against the wrong flag change no pointer. Only the bench scenarios can show the end-to-end behaviour. This covers the exact chain latencies for the first word and the first free slot, and the total capacity of N stages. It also covers the order of words and the gap-free streaming through several linked stages, along with the reset values seen at the ports.

// File: rtl/fwft_chain_pkg.sv
package fwft_chain_pkg;
  localparam int unsigned WORD_BITS     = 18;
  // cycles from accepted write to the output flag of one stage
  localparam int unsigned WR_TO_OUT_CYC = 3;
  // cycles from accepted read to the input flag of one stage
  localparam int unsigned RD_TO_IN_CYC  = 2;
  // the commit pulse reaches the head logic one cycle before the flag moves
  localparam int unsigned COMMIT_DLY    = WR_TO_OUT_CYC - 1;
  localparam int unsigned RELEASE_DLY   = RD_TO_IN_CYC;

  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/fwft_rst_sync.sv
module fwft_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/fwft_pulse_delay.sv
module fwft_pulse_delay #(
  parameter int unsigned LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic pulse_o
);
  logic [LEN-1:0] sr_q;
  logic [LEN-1:0] sr_d;

  generate
    if (LEN == 1) begin : g_single
      assign sr_d = pulse_i;
    end else begin : g_chain
      assign sr_d = {sr_q[LEN-2:0], pulse_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign pulse_o = sr_q[LEN-1];
endmodule

// File: rtl/fwft_ram.sv
module fwft_ram #(
  parameter int unsigned WIDTH = 18,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fwft_stage.sv
module fwft_stage
  import fwft_chain_pkg::*;
#(
  parameter int unsigned WIDTH = WORD_BITS,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_en_n,
  output logic             in_rdy_n,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rd_en_n,
  output logic             out_rdy_n
);
  localparam int unsigned AW = ptr_bits(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    occ_q, occ_d;
  logic [CW-1:0]    avail_q, avail_d;
  logic             head_vld_q, head_vld_d;
  logic [WIDTH-1:0] head_q;
  logic [WIDTH-1:0] ram_rdata;
  logic             wr_go, rd_go, head_load;
  logic             commit_p, release_p;

  // flags come straight from registers
  assign in_rdy_n  = (occ_q == FULL_CNT);
  assign out_rdy_n = ~head_vld_q;
  assign rd_data   = head_q;

  assign wr_go     = ~wr_en_n & ~in_rdy_n;
  assign rd_go     = ~rd_en_n & ~out_rdy_n;
  // head refills when empty or when being consumed in the same cycle
  assign head_load = (~head_vld_q | rd_go) & (avail_q != '0);

  fwft_pulse_delay #(.LEN(COMMIT_DLY)) u_commit (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (wr_go),
    .pulse_o (commit_p)
  );

  fwft_pulse_delay #(.LEN(RELEASE_DLY)) u_release (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (rd_go),
    .pulse_o (release_p)
  );

  fwft_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk     (clk),
    .we_i    (wr_go),
    .waddr_i (wptr_q),
    .wdata_i (wr_data),
    .raddr_i (rptr_q),
    .rdata_o (ram_rdata)
  );

  always_comb begin
    wptr_d     = (wptr_q == LAST_ADDR) ? '0 : wptr_q + AW'(1);
    rptr_d     = (rptr_q == LAST_ADDR) ? '0 : rptr_q + AW'(1);
    occ_d      = occ_q + CW'(wr_go) - CW'(release_p);
    avail_d    = avail_q + CW'(commit_p) - CW'(head_load);
    head_vld_d = head_vld_q;
    if (head_load) begin
      head_vld_d = 1'b1;
    end else if (rd_go) begin
      head_vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q      <= '0;
      avail_q    <= '0;
      head_vld_q <= 1'b0;
    end else begin
      occ_q      <= occ_d;
      avail_q    <= avail_d;
      head_vld_q <= head_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
    end else if (wr_go) begin
      wptr_q <= wptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      head_q <= '0;
    end else if (head_load) begin
      rptr_q <= rptr_d;
      head_q <= ram_rdata;
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= FULL_CNT); // R5
  AST_HELD_COVERS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(avail_q) + int'(head_vld_q)) <= int'(occ_q)); // R5
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_rdy_n && rd_en_n) |=> (!out_rdy_n && $stable(rd_data))); // R2
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rdy_n && avail_q != '0) |=> !out_rdy_n); // R2
  AST_FULL_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rdy_n && !wr_en_n) |=> $stable(wptr_q)); // R8
  AST_EMPTY_READ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rdy_n && avail_q == '0 && !rd_en_n) |=> (out_rdy_n && $stable(rptr_q))); // R9
endmodule

// File: rtl/fwft_chain.sv
module fwft_chain
  import fwft_chain_pkg::*;
#(
  parameter int unsigned WIDTH       = WORD_BITS,
  parameter int unsigned STAGE_DEPTH = 8,
  parameter int unsigned STAGES      = 3
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_en_n,
  output logic             in_ready_n,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rd_en_n,
  output logic             out_ready_n
);
  logic             rst_n;
  logic [WIDTH-1:0] link_data [STAGES+1];
  logic [STAGES:0]  link_wr_n;
  logic [STAGES:0]  link_rd_n;

  fwft_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  assign link_data[0]      = wr_data;
  assign link_wr_n[0]      = wr_en_n;
  assign link_rd_n[STAGES] = rd_en_n;

  // output-ready of stage i is the write enable of stage i+1;
  // input-ready of stage i+1 is the read enable of stage i
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    fwft_stage #(.WIDTH(WIDTH), .DEPTH(STAGE_DEPTH)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_data   (link_data[i]),
      .wr_en_n   (link_wr_n[i]),
      .in_rdy_n  (link_rd_n[i]),
      .rd_data   (link_data[i+1]),
      .rd_en_n   (link_rd_n[i+1]),
      .out_rdy_n (link_wr_n[i+1])
    );
  end

  assign in_ready_n  = link_rd_n[0];
  assign out_ready_n = link_wr_n[STAGES];
  assign rd_data     = link_data[STAGES];

  AST_RESET_FLAGS: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || (out_ready_n && !in_ready_n))); // R1
endmodule

// File: tb/sim_fwft_chain.sv
module sim_fwft_chain;
  localparam int W = 18;
  localparam int D = 8;
  localparam int N = 3;
  localparam int FIRST_LAT = 4 * (N - 1) + 3;
  localparam int FREE_LAT  = 3 * (N - 1) + 2;
  localparam logic [W-1:0] PAT [8] = '{18'h00001, 18'h3FFFF, 18'h15555, 18'h2AAAA,
                                        18'h00000, 18'h20000, 18'h1F0F0, 18'h0ABCD};

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic [W-1:0] din;
  logic wen_n, ren_n, w1_n, r1_n;
  logic u0_ir_n, u0_or_n, u1_ir_n, u1_or_n;
  logic [W-1:0] u0_q, u1_q;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fwft_chain #(.WIDTH(W), .STAGE_DEPTH(D), .STAGES(N)) u0 (
    .clk(clk), .arst_n(arst_n), .wr_data(din), .wr_en_n(wen_n), .in_ready_n(u0_ir_n),
    .rd_data(u0_q), .rd_en_n(ren_n), .out_ready_n(u0_or_n));

  fwft_chain #(.WIDTH(W), .STAGE_DEPTH(D), .STAGES(1)) u1 (
    .clk(clk), .arst_n(arst_n), .wr_data(din), .wr_en_n(w1_n), .in_ready_n(u1_ir_n),
    .rd_data(u1_q), .rd_en_n(r1_n), .out_ready_n(u1_or_n));

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int got;
    int acc;
    din = '0; wen_n = 1'b1; ren_n = 1'b1; w1_n = 1'b1; r1_n = 1'b1;
    step(3);
    chk(u0_or_n == 1'b1 && u0_ir_n == 1'b0, "R1 flags in reset", {u0_or_n, u0_ir_n}, 2'b10);
    chk(u0_q == '0, "R1 data in reset", u0_q, '0);
    arst_n = 1'b1;
    step(4);
    chk(u0_or_n == 1'b1 && u0_ir_n == 1'b0, "R1 flags after release", {u0_or_n, u0_ir_n}, 2'b10);
    chk(u1_or_n == 1'b1 && u1_ir_n == 1'b0 && u1_q == '0, "R1 single stage idle", u1_q, '0);

    // R3 and R2 on a single stage
    din = PAT[1]; w1_n = 1'b0;
    step(1); w1_n = 1'b1;
    step(2);
    chk(u1_or_n == 1'b1, "R3 flag still high after k+2", u1_or_n, 1);
    step(1);
    chk(u1_or_n == 1'b0 && u1_q == PAT[1], "R3 word presented after k+3", u1_q, PAT[1]);
    step(3);
    chk(u1_or_n == 1'b0 && u1_q == PAT[1], "R2 word held without read", u1_q, PAT[1]);
    r1_n = 1'b0; step(1); r1_n = 1'b1;
    chk(u1_or_n == 1'b1, "R2 empty after last read", u1_or_n, 1);

    // R4 first word through the empty chain
    din = PAT[2]; wen_n = 1'b0;
    step(1); wen_n = 1'b1;
    step(FIRST_LAT - 1);
    chk(u0_or_n == 1'b1, "R4 flag still high one cycle early", u0_or_n, 1);
    step(1);
    chk(u0_or_n == 1'b0 && u0_q == PAT[2], "R4 first word at chain output", u0_q, PAT[2]);
    ren_n = 1'b0; step(1); ren_n = 1'b1;
    chk(u0_or_n == 1'b1, "R2 chain empty after read", u0_or_n, 1);

    // R7 table-driven burst with the read held active
    ren_n = 1'b0; got = 0;
    for (int c = 0; c < 40; c++) begin
      if (!u0_or_n) begin
        if (got < 8) chk(u0_q == PAT[got], "R7 order", u0_q, PAT[got]);
        got++;
      end else if (got > 0 && got < 8) begin
        chk(1'b0, "R7 gap in stream", W'(got), 8);
      end
      if (c < 8) begin
        din = PAT[c]; wen_n = 1'b0;
      end else begin
        wen_n = 1'b1;
      end
      step(1);
    end
    chk(got == 8, "R7 burst count", W'(got), 8);
    ren_n = 1'b1;

    // R5 capacity
    acc = 0;
    for (int c = 0; c < 150; c++) begin
      if (!u0_ir_n) begin
        din = W'(acc); wen_n = 1'b0; acc++;
      end else begin
        wen_n = 1'b1;
      end
      step(1);
    end
    wen_n = 1'b1;
    chk(acc == N * D, "R5 accepted words", W'(acc), W'(N * D));
    chk(u0_ir_n == 1'b1, "R5 full flag", u0_ir_n, 1);

    // R8 writes against a full chain
    din = 18'h2AAAA; wen_n = 1'b0;
    step(5); wen_n = 1'b1;
    chk(u0_ir_n == 1'b1, "R8 still full", u0_ir_n, 1);

    // R6 first free slot latency
    chk(u0_or_n == 1'b0 && u0_q == '0, "R7 head is oldest", u0_q, '0);
    ren_n = 1'b0; step(1); ren_n = 1'b1;
    step(FREE_LAT - 1);
    chk(u0_ir_n == 1'b1, "R6 still full one cycle early", u0_ir_n, 1);
    step(1);
    chk(u0_ir_n == 1'b0, "R6 free slot reached input", u0_ir_n, 0);

    // drain: R8 nothing extra stored, R9 reads on empty ignored
    ren_n = 1'b0; got = 1;
    for (int c = 0; c < 120; c++) begin
      if (!u0_or_n) begin
        chk(u0_q == W'(got), "R8 drain order", u0_q, W'(got));
        got++;
      end
      step(1);
    end
    chk(got == N * D, "R8 drained count", W'(got), W'(N * D));
    chk(u0_or_n == 1'b1, "R9 empty after drain", u0_or_n, 1);
    ren_n = 1'b1;
    din = 18'h3FFFF; wen_n = 1'b0;
    step(1); wen_n = 1'b1;
    step(15);
    chk(u0_or_n == 1'b0 && u0_q == 18'h3FFFF, "R9 word after empty reads", u0_q, 18'h3FFFF);
    ren_n = 1'b0; step(1); ren_n = 1'b1;
    chk(u0_or_n == 1'b1 && u0_ir_n == 1'b0, "R9 single word only", {u0_or_n, u0_ir_n}, 2'b10);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule